// File: doc/BRIEF.md
# March memory self-test engine

This block is a built-in self-test sequencer for a single-port synchronous RAM. On a start pulse it checks the requested byte range, then runs one of three March algorithms over the words of that range. It drives the RAM's address, write-data and write-enable lines and compares each read word against the expected background. A "0" operation uses the all-zeros word and a "1" operation uses the all-ones word. Any single bit difference counts as a mismatch.

Each algorithm is a fixed list of elements. Each element visits every word of the range in ascending or descending order and applies one to six operations to each word before it moves to the next word. A read asserts the address in one cycle and compares the returned data in the next cycle, because the RAM has one cycle of read latency. The test is destructive. On a passing run every word of the range is left at zero.

The state machine has four named states. `ST_IDLE` is the state after reset. `ST_RUN` issues one operation per cycle. `ST_CMP` compares read data. `ST_DONE` holds the result. The transitions are:
- start with a valid range: `ST_IDLE`/`ST_DONE` to `ST_RUN`
- start with an invalid range: `ST_IDLE`/`ST_DONE` to `ST_DONE` with fail
- the operation is a read: `ST_RUN` to `ST_CMP`
- the operation is a write and more work remains: `ST_RUN` to `ST_RUN`
- the read data matches: `ST_CMP` to `ST_RUN`
- the read data mismatches: `ST_CMP` to `ST_DONE` with fail
- the last operation of the last element completes: `ST_RUN` or `ST_CMP` to `ST_DONE` with pass

Top module: `march_bist`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `pass` and `mem_we` are all 0.
- R2: A start is rejected in either of two cases. The first is an unusable range: `rng_base` is not a multiple of 2 bytes, `rng_len` is not a multiple of 2 bytes, `rng_len` is zero, or `rng_base + rng_len` exceeds 128 bytes. The second is `alg_sel` = 3. A rejected start sets `done`=1 and `pass`=0 after one clock edge, with no RAM write.
- R3: `alg_sel` = 2 (March B) is rejected under R2 when the range holds an odd number of words. `alg_sel` = 0 and `alg_sel` = 1 accept odd word counts.
- R4: `alg_sel` = 0 runs March C: up(w0); up(r0,w1); up(r1,w0); up(r0); down(r0,w1); down(r1,w0); up(r0). A clean run over N words raises `done` with `pass`=1 on edge 1+17N, where the start edge is edge 1.
- R5: `alg_sel` = 1 runs March C minus: up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0). A clean run gives `done`=1 and `pass`=1 on edge 1+15N.
- R6: `alg_sel` = 2 runs March B: up(w0); up(r0,w1,r1,w0,r0,w1); up(r1,w0,w1); down(r1,w0,w1,w0); down(r0,w1,w0). A clean run gives `done`=1 and `pass`=1 on edge 1+23N.
- R7: Read data is compared in the cycle after its address is issued. On the first mismatch the engine stops and raises `done` with `pass`=0. `fail_addr` then holds the word index of the mismatching read.
- R8: After a pass, every word in the range reads 0. No word outside the range is ever written.
- R9: A start while `busy` is 1 is ignored. The running test keeps its algorithm, its range and its finishing edge.
- R10: `done` and `pass` hold until the next start, and a new start is accepted from the done state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled while not busy |
| alg_sel | input | 2 | 0 March C, 1 March C minus, 2 March B, 3 invalid |
| rng_base | input | 7 | Byte address of the first byte of the range |
| rng_len | input | 8 | Range length in bytes |
| mem_addr | output | 6 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | 16 | RAM read data, one cycle after the address |
| busy | output | 1 | Test in progress |
| done | output | 1 | Result valid |
| pass | output | 1 | 1 pass, 0 fail; valid with done |
| fail_addr | output | 6 | Word index of the first mismatch |

## Verification
A rejected start yields its result one edge after the start edge. A clean run yields its result 1+K·N edges after the start edge, where K is 17, 15 or 23 for the selected algorithm: each write takes one cycle and each read takes two. The bench drives the start pulse on a falling edge and counts rising edges until it sees `done` on a falling edge. It compares that count with the formula exactly, so an extra or missing cycle anywhere in the sequence shows up. A faulty run is checked on its failing word index, and the RAM contents inside and outside the range are checked once `done` is seen.

// File: rtl/march_pkg.sv
package march_pkg;

    typedef enum logic [1:0] {
        ALG_C   = 2'd0,
        ALG_CM  = 2'd1,
        ALG_B   = 2'd2,
        ALG_BAD = 2'd3
    } alg_e;

    typedef enum logic [1:0] {
        OP_W0 = 2'd0,
        OP_W1 = 2'd1,
        OP_R0 = 2'd2,
        OP_R1 = 2'd3
    } op_e;

    localparam int MAX_OPS = 6;

    typedef struct packed {
        logic                  down;
        logic [2:0]            nops;
        op_e [MAX_OPS-1:0]     ops;
    } elem_t;

    function automatic elem_t mk_elem(input logic dn, input logic [2:0] n,
                                      input op_e a, input op_e b, input op_e c,
                                      input op_e d, input op_e e, input op_e f);
        elem_t r;
        r.down = dn;
        r.nops = n;
        r.ops  = {f, e, d, c, b, a};
        return r;
    endfunction

    function automatic logic [2:0] elem_count(input alg_e a);
        unique case (a)
            ALG_C:   return 3'd7;
            ALG_CM:  return 3'd6;
            ALG_B:   return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    function automatic elem_t elem_at(input alg_e a, input logic [2:0] i);
        elem_t z;
        z = mk_elem(1'b0, 3'd1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
        unique case (a)
            ALG_C: case (i)
                3'd1: z = mk_elem(1'b0, 3'd2, OP_R0, OP_W1, OP_W0, OP_W0, OP_W0, OP_W0);
                3'd2: z = mk_elem(1'b0, 3'd2, OP_R1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
                3'd3: z = mk_elem(1'b0, 3'd1, OP_R0, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
                3'd4: z = mk_elem(1'b1, 3'd2, OP_R0, OP_W1, OP_W0, OP_W0, OP_W0, OP_W0);
                3'd5: z = mk_elem(1'b1, 3'd2, OP_R1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
                3'd6: z = mk_elem(1'b0, 3'd1, OP_R0, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
                default: ;
            endcase
            ALG_CM: case (i)
                3'd1: z = mk_elem(1'b0, 3'd2, OP_R0, OP_W1, OP_W0, OP_W0, OP_W0, OP_W0);
                3'd2: z = mk_elem(1'b0, 3'd2, OP_R1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
                3'd3: z = mk_elem(1'b1, 3'd2, OP_R0, OP_W1, OP_W0, OP_W0, OP_W0, OP_W0);
                3'd4: z = mk_elem(1'b1, 3'd2, OP_R1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
                3'd5: z = mk_elem(1'b0, 3'd1, OP_R0, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
                default: ;
            endcase
            ALG_B: case (i)
                3'd1: z = mk_elem(1'b0, 3'd6, OP_R0, OP_W1, OP_R1, OP_W0, OP_R0, OP_W1);
                3'd2: z = mk_elem(1'b0, 3'd3, OP_R1, OP_W0, OP_W1, OP_W0, OP_W0, OP_W0);
                3'd3: z = mk_elem(1'b1, 3'd4, OP_R1, OP_W0, OP_W1, OP_W0, OP_W0, OP_W0);
                3'd4: z = mk_elem(1'b1, 3'd3, OP_R0, OP_W1, OP_W0, OP_W0, OP_W0, OP_W0);
                default: ;
            endcase
            default: ;
        endcase
        return z;
    endfunction

endpackage

// File: rtl/march_range_chk.sv
module march_range_chk
    import march_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WORDS  = 64,
    localparam int ADDR_W  = $clog2(WORDS),
    localparam int WB      = DATA_W / 8,
    localparam int BYTE_AW = ADDR_W + $clog2(WB),
    localparam int LEN_W   = BYTE_AW + 1
) (
    input  logic [BYTE_AW-1:0] base_i,
    input  logic [LEN_W-1:0]   len_i,
    input  alg_e               alg_i,
    output logic               ok_o,
    output logic [ADDR_W-1:0]  lo_o,
    output logic [ADDR_W-1:0]  hi_o
);
    localparam int CW = LEN_W + 1;
    localparam logic [CW-1:0] WBV = CW'(WB);
    localparam logic [CW-1:0] CAP = CW'(WORDS * WB);

    logic [CW-1:0] b, l, e, nw;

    always_comb begin
        b  = CW'(base_i);
        l  = CW'(len_i);
        e  = b + l;
        nw = l / WBV;
        ok_o = ((b % WBV) == '0) && ((l % WBV) == '0) && (l != '0) &&
               (e <= CAP) && (alg_i != ALG_BAD) &&
               !((alg_i == ALG_B) && nw[0]);
        lo_o = ADDR_W'(b / WBV);
        hi_o = ADDR_W'((e / WBV) - CW'(1));
    end

endmodule

// File: rtl/march_addr_walk.sv
module march_addr_walk #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    input  logic              init_i,
    input  logic              init_dir_i,
    input  logic              step_i,
    input  logic              dir_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    logic [ADDR_W-1:0] lo_q, hi_q, addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            addr_q <= '0;
        end else if (load_i) begin
            lo_q   <= lo_i;
            hi_q   <= hi_i;
            addr_q <= lo_i;
        end else if (init_i) begin
            addr_q <= init_dir_i ? hi_q : lo_q;
        end else if (step_i) begin
            addr_q <= dir_i ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    assign addr_o = addr_q;
    assign last_o = dir_i ? (addr_q == lo_q) : (addr_q == hi_q);

    // R8: the sequencer never steps beyond the end of the window
    a_r8_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !last_o);

endmodule

// File: rtl/march_bist.sv
module march_bist
    import march_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WORDS  = 64,
    localparam int ADDR_W  = $clog2(WORDS),
    localparam int BYTE_AW = ADDR_W + $clog2(DATA_W / 8),
    localparam int LEN_W   = BYTE_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         alg_sel,
    input  logic [BYTE_AW-1:0] rng_base,
    input  logic [LEN_W-1:0]   rng_len,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               pass,
    output logic [ADDR_W-1:0]  fail_addr
);
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_CMP, ST_DONE} state_e;

    state_e state, state_d;
    alg_e              alg_q, alg_d;
    logic [2:0]        el_q, el_d, op_q, op_d;
    logic              pass_q, pass_d;
    logic [ADDR_W-1:0] fail_q, fail_d;

    logic              rng_ok;
    logic [ADDR_W-1:0] rng_lo, rng_hi;
    logic              w_load, w_init, w_step, w_last, adv;
    logic [ADDR_W-1:0] w_addr;
    elem_t             cur, nxt;
    op_e               op;
    logic              is_rd;
    logic [DATA_W-1:0] exp_w;

    march_range_chk #(.DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
        .base_i (rng_base),
        .len_i  (rng_len),
        .alg_i  (alg_e'(alg_sel)),
        .ok_o   (rng_ok),
        .lo_o   (rng_lo),
        .hi_o   (rng_hi)
    );

    march_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (w_load),
        .lo_i       (rng_lo),
        .hi_i       (rng_hi),
        .init_i     (w_init),
        .init_dir_i (nxt.down),
        .step_i     (w_step),
        .dir_i      (cur.down),
        .addr_o     (w_addr),
        .last_o     (w_last)
    );

    // Current element and operation
    always_comb begin
        cur   = elem_at(alg_q, el_q);
        nxt   = elem_at(alg_q, el_q + 3'd1);
        op    = cur.ops[op_q];
        is_rd = (op == OP_R0) || (op == OP_R1);
        exp_w = (op == OP_R1) ? '1 : '0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            alg_q  <= ALG_C;
            el_q   <= '0;
            op_q   <= '0;
            pass_q <= 1'b0;
            fail_q <= '0;
        end else begin
            state  <= state_d;
            alg_q  <= alg_d;
            el_q   <= el_d;
            op_q   <= op_d;
            pass_q <= pass_d;
            fail_q <= fail_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state;
        alg_d   = alg_q;
        el_d    = el_q;
        op_d    = op_q;
        pass_d  = pass_q;
        fail_d  = fail_q;
        w_load  = 1'b0;
        w_init  = 1'b0;
        w_step  = 1'b0;
        adv     = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    pass_d = 1'b0;
                    fail_d = '0;
                    if (rng_ok) begin
                        state_d = ST_RUN;
                        alg_d   = alg_e'(alg_sel);
                        el_d    = '0;
                        op_d    = '0;
                        w_load  = 1'b1;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_RUN: begin
                if (is_rd) state_d = ST_CMP;
                else       adv     = 1'b1;
            end
            ST_CMP: begin
                if (mem_rdata != exp_w) begin
                    state_d = ST_DONE;
                    pass_d  = 1'b0;
                    fail_d  = w_addr;
                end else begin
                    adv = 1'b1;
                end
            end
        endcase
        if (adv) begin
            state_d = ST_RUN;
            if (op_q != cur.nops - 3'd1) begin
                op_d = op_q + 3'd1;
            end else if (!w_last) begin
                op_d   = '0;
                w_step = 1'b1;
            end else if (el_q != elem_count(alg_q) - 3'd1) begin
                el_d   = el_q + 3'd1;
                op_d   = '0;
                w_init = 1'b1;
            end else begin
                state_d = ST_DONE;
                pass_d  = 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_addr  = w_addr;
        mem_we    = (state == ST_RUN) && !is_rd;
        mem_wdata = (op == OP_W1) ? '1 : '0;
        busy      = (state == ST_RUN) || (state == ST_CMP);
        done      = (state == ST_DONE);
        pass      = pass_q;
        fail_addr = fail_q;
    end

    // R2: a rejected start reports fail on the next edge
    a_r2_reject_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !rng_ok) |=> (done && !pass && !busy));

    // R7: a mismatch stops the run and records the address that was read
    a_r7_mismatch_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP && mem_rdata != exp_w) |=>
            (done && !pass && fail_addr == $past(mem_addr)));

    // R7: compare happens one cycle after the read was issued, address held
    a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP) |-> ($past(state) == ST_RUN && $stable(mem_addr)));

    // R9: the algorithm cannot change while a test runs
    a_r9_alg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(alg_q));

    // R4: a run never ends anywhere but the done state
    a_r4_end_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: the result holds until a new start
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass)));

endmodule

// File: tb/march_bist_tb.sv
module march_bist_tb;
    localparam int DATA_W = 16;
    localparam int WORDS  = 64;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        alg_sel = '0;
    logic [6:0]        rng_base = '0;
    logic [7:0]        rng_len = '0;
    logic [ADDR_W-1:0] mem_addr, fail_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              mem_we, busy, done, pass;

    logic [DATA_W-1:0] ram [WORDS];
    logic [DATA_W-1:0] rd_q = '0;
    logic [ADDR_W-1:0] rd_a = '0;
    logic              flt_en = 1'b0;
    logic              flt_val = 1'b0;
    logic [ADDR_W-1:0] flt_addr = '0;
    logic [DATA_W-1:0] flt_mask = '0;
    int                wr_cnt = 0;
    int                nchk = 0;
    int                nerr = 0;

    always #10 clk = ~clk;

    march_bist u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
        .rng_base(rng_base), .rng_len(rng_len), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
    );

    // RAM model: one cycle read latency, optional stuck bit on one word
    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        rd_q <= ram[mem_addr];
        rd_a <= mem_addr;
    end

    assign mem_rdata = (flt_en && rd_a == flt_addr) ?
                       (flt_val ? (rd_q | flt_mask) : (rd_q & ~flt_mask)) : rd_q;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] sentinel(input int i);
        return DATA_W'(i * 37 + 4660) ^ 16'hA5C3;
    endfunction

    function automatic bit rng_valid(input int alg, input int base, input int len);
        return alg < 3 && base % 2 == 0 && len % 2 == 0 && len > 0 &&
               base + len <= 128 && !(alg == 2 && (len / 2) % 2 == 1);
    endfunction

    function automatic int cost(input int alg);
        return alg == 0 ? 17 : (alg == 1 ? 15 : 23);
    endfunction

    task automatic run(input int alg, input int base, input int len,
                       input bit fen, input int fa, input int fb, input bit fv,
                       input bit mid, input string tag);
        int cnt;
        int w0;
        int lo, hi, n;
        bit valid, hit;
        for (int i = 0; i < WORDS; i++) ram[i] = sentinel(i);
        valid = rng_valid(alg, base, len);
        lo = base / 2;
        n  = len / 2;
        hi = lo + n - 1;
        hit = fen && fa >= lo && fa <= hi;
        @(negedge clk);
        flt_en   = fen;
        flt_addr = ADDR_W'(fa);
        flt_mask = DATA_W'(1) << fb;
        flt_val  = fv;
        alg_sel  = 2'(alg);
        rng_base = 7'(base);
        rng_len  = 8'(len);
        start    = 1'b1;
        w0       = wr_cnt;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 4000) begin
            @(negedge clk);
            cnt++;
            if (mid && cnt == 5) begin
                start   = 1'b1;
                alg_sel = 2'd3;
            end else if (mid && cnt == 6) begin
                start = 1'b0;
            end
        end
        chk(done == 1'b1, tag, "done seen", int'(done), 1);
        if (!valid) begin
            chk(cnt == 1, tag, "reject latency", cnt, 1);
            chk(pass == 1'b0, tag, "reject pass", int'(pass), 0);
            chk(wr_cnt == w0, "R2", "writes on reject", wr_cnt - w0, 0);
        end else if (hit) begin
            chk(pass == 1'b0, "R7", "pass on fault", int'(pass), 0);
            chk(int'(fail_addr) == fa, "R7", "fail_addr", int'(fail_addr), fa);
        end else begin
            chk(pass == 1'b1, tag, "pass", int'(pass), 1);
            chk(cnt == 1 + cost(alg) * n, tag, "done edge", cnt, 1 + cost(alg) * n);
            for (int i = lo; i <= hi; i++)
                if (ram[i] != '0) chk(1'b0, "R8", "word not cleared", int'(ram[i]), 0);
            nchk++;
        end
        if (valid) begin
            for (int i = 0; i < WORDS; i++)
                if ((i < lo || i > hi) && ram[i] != sentinel(i))
                    chk(1'b0, "R8", "outside word changed", int'(ram[i]), int'(sentinel(i)));
            nchk++;
        end
        flt_en = 1'b0;
    endtask

    initial begin
        int alg, n, bw, fa;
        bit fen;
        void'($urandom(32'd2024));
        for (int i = 0; i < WORDS; i++) ram[i] = sentinel(i);
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && pass == 0 && mem_we == 0, "R1", "in reset",
            int'({busy, done, pass, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && pass == 0 && mem_we == 0, "R1", "after reset",
            int'({busy, done, pass, mem_we}), 0);

        run(0, 0, 2, 0, 0, 0, 0, 0, "R4");
        run(0, 6, 40, 0, 0, 0, 0, 0, "R4");
        run(1, 10, 20, 0, 0, 0, 0, 0, "R5");
        run(2, 0, 128, 0, 0, 0, 0, 0, "R6");
        run(2, 2, 6, 0, 0, 0, 0, 0, "R3");
        run(0, 2, 6, 0, 0, 0, 0, 0, "R3");
        run(1, 2, 6, 0, 0, 0, 0, 0, "R3");
        run(0, 1, 4, 0, 0, 0, 0, 0, "R2");
        run(0, 0, 3, 0, 0, 0, 0, 0, "R2");
        run(1, 0, 0, 0, 0, 0, 0, 0, "R2");
        run(1, 120, 10, 0, 0, 0, 0, 0, "R2");
        run(3, 0, 8, 0, 0, 0, 0, 0, "R2");
        run(0, 0, 32, 1, 5, 3, 1, 0, "R7");
        run(2, 64, 64, 1, 63, 15, 0, 0, "R7");
        run(1, 0, 8, 1, 20, 0, 1, 0, "R8");
        run(0, 0, 16, 0, 0, 0, 0, 1, "R9");

        // R10: result holds, then a new start is taken from done
        repeat (5) @(negedge clk);
        chk(done == 1'b1 && pass == 1'b1, "R10", "result held", int'({done, pass}), 3);
        run(1, 4, 4, 0, 0, 0, 0, 0, "R10");

        for (int t = 0; t < 24; t++) begin
            alg = int'($urandom % 3);
            n   = 1 + int'($urandom % WORDS);
            if (alg == 2 && n % 2 == 1) n = n + 1;
            bw  = int'($urandom % (WORDS - n + 1));
            fen = 1'($urandom % 2);
            fa  = bw + int'($urandom % n);
            run(alg, bw * 2, n * 2, fen, fa, int'($urandom % 16), 1'($urandom % 2),
                0, alg == 0 ? "R4" : (alg == 1 ? "R5" : "R6"));
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(20 * 190000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule